// File: doc/BRIEF.md
# Aligned Dual-Ratio Clock Divider

This block derives two divided clock outputs from one input clock. Output group A runs at one half or one quarter of the input rate. Output group B runs at one quarter or one sixth of the input rate. Each group has its own ratio-select input. Both outputs are decoded from a single shared phase counter. That counter walks through a frame of 12 input cycles, which is the least common multiple of the ratios. Rising edges that the two groups have in common therefore always land on the same input clock edge.

The run/stop control is captured by a flop on the falling input edge. The dividers start and stop only at the frame boundary, where every output is low, so a change of the control never produces a short pulse. Ratio selects are also adopted at the frame boundary. A synchronous, active-high reset parks the counter at the last frame position with all outputs low. Several instances can then be released together and run in lock-step.

Top module: `clkdiv_dual`

## Requirements
- R1: With `sel_a`=0, `out_a` divides by 2 (high 1 cycle, low 1 cycle). With `sel_a`=1 it divides by 4 (high 2, low 2). Frame position p drives `out_a` high when (p mod ratio) < ratio/2.
- R2: With `sel_b`=0, `out_b` divides by 4 (high 2, low 2). With `sel_b`=1 it divides by 6 (high 3, low 3), using the same decode rule as R1.
- R3: The frame is 12 input cycles long. On its first position (p=0) both outputs are high, having risen on the same input edge. Every rising edge of either output falls on a frame position that is a multiple of its ratio.
- R4: `en` is sampled only on the falling edge of `clk`. A change made after a falling edge takes effect one cycle later than a change made before it. A high level that is gone before the next falling edge is ignored.
- R5: Once `en` is sampled low, the outputs continue their pattern up to the end of the current frame and then stop. No high pulse is ever shorter than half the selected period.
- R6: From the stopped state, the first rising edge that follows a sampled-high `en` starts a new frame at p=0, with both outputs rising together.
- R7: `rst` (synchronous, active high) forces both outputs low, the counter to the last frame position and the enable flop low. Two instances reset together and released with `en` high produce identical outputs.
- R8: A change of `sel_a` or `sel_b` is adopted only at the start of the next frame. Until then the old ratio keeps running.
- R9: While stopped, both outputs stay low and the frame position does not move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high master reset |
| en | input | 1 | Run/stop control, captured on the falling clock edge |
| sel_a | input | 1 | Group A ratio: 0 = divide by 2, 1 = divide by 4 |
| sel_b | input | 1 | Group B ratio: 0 = divide by 4, 1 = divide by 6 |
| out_a | output | 1 | Group A divided clock, registered |
| out_b | output | 1 | Group B divided clock, registered |

## Verification
The hardest condition to reach is a control change that arrives part-way through a frame. One case is `en` dropping in mid-pattern. Another is an `en` pulse that falls between two falling edges and is never captured. The directed tasks place these changes at the sampling instant or just past a falling edge. They then follow every output sample to the frame end, through the stopped state and into the restart. A second instance is started a few cycles out of phase and then reset together with the first, to show that both lock to the same phase.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic {
        RATIO_FAST = 1'b0,
        RATIO_SLOW = 1'b1
    } ratio_e;

    localparam int NUM_GRP = 2;

    function automatic int gcd_f(input int x, input int y);
        int a = x;
        int b = y;
        int t;
        while (b != 0) begin
            t = a % b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    function automatic int lcm_f(input int x, input int y);
        return (x / gcd_f(x, y)) * y;
    endfunction

    // high during the first half of each period of length div
    function automatic logic is_high(input int pos, input int div);
        return (pos % div) < (div / 2);
    endfunction

endpackage

// File: rtl/clkdiv_en_sync.sv
module clkdiv_en_sync (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic en_q
);
    // captured on the falling edge so the decision is ready half a cycle
    // before the rising edge that advances the frame
    always_ff @(negedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en;
    end
endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase #(
    parameter int FRAME = 12,
    parameter int PW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_q,
    output logic [PW-1:0] phase_q,
    output logic [PW-1:0] phase_nxt,
    output logic          restart
);
    localparam logic [PW-1:0] LAST = PW'(FRAME - 1);

    logic at_end;

    always_comb begin
        at_end  = (phase_q == LAST);
        restart = at_end && en_q;
        if (at_end) phase_nxt = en_q ? '0 : LAST;
        else        phase_nxt = phase_q + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= LAST;
        else     phase_q <= phase_nxt;
    end
endmodule

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
    import clkdiv_pkg::*;
#(
    parameter int FAST = 2,
    parameter int SLOW = 4,
    parameter int PW   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [PW-1:0] phase_nxt,
    input  logic          sel_in,
    output logic          sel_q,
    output logic          out_q
);
    ratio_e sel_r;
    ratio_e sel_eff;
    logic   hi;

    always_comb begin
        sel_eff = restart ? ratio_e'(sel_in) : sel_r;
        if (sel_eff == RATIO_SLOW) hi = is_high(int'(phase_nxt), SLOW);
        else                       hi = is_high(int'(phase_nxt), FAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_r <= RATIO_FAST;
            out_q <= 1'b0;
        end else begin
            if (restart) sel_r <= ratio_e'(sel_in);
            out_q <= hi;
        end
    end

    assign sel_q = sel_r;
endmodule

// File: rtl/clkdiv_dual.sv
module clkdiv_dual
    import clkdiv_pkg::*;
#(
    parameter int A_FAST = 2,
    parameter int A_SLOW = 4,
    parameter int B_FAST = 4,
    parameter int B_SLOW = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic sel_a,
    input  logic sel_b,
    output logic out_a,
    output logic out_b
);
    localparam int FRAME = lcm_f(lcm_f(A_FAST, A_SLOW), lcm_f(B_FAST, B_SLOW));
    localparam int PW    = $clog2(FRAME);

    logic               en_q;
    logic [PW-1:0]      phase_q;
    logic [PW-1:0]      phase_nxt;
    logic               restart;
    logic [NUM_GRP-1:0] sel_vec;
    logic [NUM_GRP-1:0] sel_q_vec;
    logic [NUM_GRP-1:0] out_vec;

    assign sel_vec = {sel_b, sel_a};

    clkdiv_en_sync u_en (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .en_q (en_q)
    );

    clkdiv_phase #(.FRAME(FRAME), .PW(PW)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .en_q      (en_q),
        .phase_q   (phase_q),
        .phase_nxt (phase_nxt),
        .restart   (restart)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int GF = (g == 0) ? A_FAST : B_FAST;
        localparam int GS = (g == 0) ? A_SLOW : B_SLOW;
        clkdiv_decode #(.FAST(GF), .SLOW(GS), .PW(PW)) u_dec (
            .clk       (clk),
            .rst       (rst),
            .restart   (restart),
            .phase_nxt (phase_nxt),
            .sel_in    (sel_vec[g]),
            .sel_q     (sel_q_vec[g]),
            .out_q     (out_vec[g])
        );
    end

    assign out_a = out_vec[0];
    assign out_b = out_vec[1];
endmodule

// File: rtl/clkdiv_dual_chk.sv
module clkdiv_dual_chk
    import clkdiv_pkg::*;
#(
    parameter int FRAME = 12,
    parameter int PW    = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               en_q,
    input logic [PW-1:0]      phase_q,
    input logic [NUM_GRP-1:0] sel_q_vec,
    input logic               out_a,
    input logic               out_b
);
    localparam logic [PW-1:0] LAST = PW'(FRAME - 1);

    assert_reset_R7: assert property (@(posedge clk)
        rst |=> (!out_a && !out_b && phase_q == LAST));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (phase_q == LAST && !en_q) |=> (phase_q == LAST && !out_a && !out_b));

    assert_step_R5: assert property (@(posedge clk) disable iff (rst)
        (phase_q != LAST) |=> (phase_q == $past(phase_q) + PW'(1)));

    assert_align_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == '0) |-> (out_a && out_b));

    assert_sel_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_q_vec) |-> (phase_q == '0));

    assert_no_runt_a_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_a) && sel_q_vec[0]) |=> out_a);

    assert_no_runt_b_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_b) && sel_q_vec[1]) |=> out_b);
endmodule

bind clkdiv_dual clkdiv_dual_chk #(.FRAME(FRAME), .PW(PW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_q      (en_q),
    .phase_q   (phase_q),
    .sel_q_vec (sel_q_vec),
    .out_a     (out_a),
    .out_b     (out_b)
);

// File: tb/tb_clkdiv_dual.sv
module tb_clkdiv_dual;
    localparam int FRM = 12;

    logic clk = 1'b0;
    logic rst, rst2, en, en2, sel_a, sel_b;
    logic out_a, out_b, out2_a, out2_b;
    int   nchk = 0;
    int   nbad = 0;

    always #5 clk = ~clk;

    clkdiv_dual dut (
        .clk(clk), .rst(rst), .en(en), .sel_a(sel_a), .sel_b(sel_b),
        .out_a(out_a), .out_b(out_b)
    );

    clkdiv_dual dut2 (
        .clk(clk), .rst(rst2), .en(en2), .sel_a(sel_a), .sel_b(sel_b),
        .out_a(out2_a), .out_b(out2_b)
    );

    function automatic bit exp_hi(input int p, input int d);
        return (p % d) < (d / 2);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // advance to the sampling point 2 ns after a rising edge
    task automatic step;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset;
        rst = 1'b1; rst2 = 1'b1; en = 1'b0; en2 = 1'b0;
        step; step;
        rst = 1'b0; rst2 = 1'b0;
    endtask

    task automatic run_expect(input int start, input int n, input int da, input int db,
                              input string req);
        for (int i = 0; i < n; i++) begin
            int p;
            step;
            p = (start + i) % FRM;
            chk(out_a == exp_hi(p, da), {req, " out_a"}, int'(out_a), int'(exp_hi(p, da)));
            chk(out_b == exp_hi(p, db), {req, " out_b"}, int'(out_b), int'(exp_hi(p, db)));
            if (p == 0) chk(out_a && out_b, "R3 common rise", int'({out_a, out_b}), 3);
        end
    endtask

    task automatic expect_low(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            step;
            chk(!out_a && !out_b, req, int'({out_a, out_b}), 0);
        end
    endtask

    task automatic t_reset;
        sel_a = 1'b0; sel_b = 1'b0;
        do_reset;
        chk(!out_a && !out_b, "R7 reset outputs", int'({out_a, out_b}), 0);
        expect_low(15, "R9 stopped low");
        en = 1'b1;
        run_expect(0, 7, 2, 4, "R1 R2 pre-reset run");
        rst = 1'b1;
        step;
        chk(!out_a && !out_b, "R7 mid-run reset", int'({out_a, out_b}), 0);
        en = 1'b0;
        step;
        rst = 1'b0;
        expect_low(5, "R9 after reset");
    endtask

    task automatic t_ratio(input bit sa, input bit sb);
        int da, db;
        da = sa ? 4 : 2;
        db = sb ? 6 : 4;
        sel_a = sa; sel_b = sb;
        do_reset;
        en = 1'b1;
        step;
        chk(out_a && out_b, "R6 first rise together", int'({out_a, out_b}), 3);
        run_expect(1, 2 * FRM, da, db, "R1 R2 ratio pattern");
    endtask

    task automatic t_en_edge;
        sel_a = 1'b1; sel_b = 1'b1;
        do_reset;
        #4;                  // just past the falling edge
        en = 1'b1;
        step;
        chk(!out_a && !out_b, "R4 late enable not yet seen", int'({out_a, out_b}), 0);
        step;
        chk(out_a && out_b, "R4 late enable seen", int'({out_a, out_b}), 3);
        do_reset;
        #4;
        en = 1'b1;
        step;                // removed before the next falling edge
        en = 1'b0;
        expect_low(FRM + 1, "R4 uncaptured pulse ignored");
    endtask

    task automatic t_disable;
        sel_a = 1'b1; sel_b = 1'b1;
        do_reset;
        en = 1'b1;
        run_expect(0, 6, 4, 6, "R5 before stop");
        en = 1'b0;
        run_expect(6, 6, 4, 6, "R5 finish frame");
        expect_low(10, "R9 held low");
        en = 1'b1;
        step;
        chk(out_a && out_b, "R6 restart together", int'({out_a, out_b}), 3);
        run_expect(1, 11, 4, 6, "R6 restart pattern");
        en = 1'b0;
        expect_low(1, "R5 stop at frame end");
    endtask

    task automatic t_sel_change;
        sel_a = 1'b0; sel_b = 1'b0;
        do_reset;
        en = 1'b1;
        run_expect(0, 5, 2, 4, "R8 old ratio");
        sel_a = 1'b1; sel_b = 1'b1;
        run_expect(5, 7, 2, 4, "R8 old ratio kept");
        run_expect(0, FRM, 4, 6, "R8 new ratio");
    endtask

    task automatic t_two;
        sel_a = 1'b1; sel_b = 1'b1;
        do_reset;
        en = 1'b1;
        repeat (5) step;
        en2 = 1'b1;
        repeat (7) step;
        rst = 1'b1; rst2 = 1'b1;
        step; step;
        rst = 1'b0; rst2 = 1'b0;
        for (int i = 0; i < 2 * FRM; i++) begin
            step;
            chk(out_a == out2_a && out_b == out2_b, "R7 two instances aligned",
                int'({out2_a, out2_b}), int'({out_a, out_b}));
            chk(out_a == exp_hi(i, 4) && out_b == exp_hi(i, 6), "R7 post-reset phase",
                int'({out_a, out_b}), int'({exp_hi(i, 4), exp_hi(i, 6)}));
        end
    endtask

    initial begin
        rst = 1'b1; rst2 = 1'b1; en = 1'b0; en2 = 1'b0; sel_a = 1'b0; sel_b = 1'b0;
        t_reset;
        t_ratio(1'b0, 1'b0);
        t_ratio(1'b0, 1'b1);
        t_ratio(1'b1, 1'b0);
        t_ratio(1'b1, 1'b1);
        t_en_edge;
        t_disable;
        t_sel_change;
        t_two;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nbad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule